// File: doc/BRIEF.md
# Hot-plug Slot Event Interrupt Aggregator

This block gathers hot-plug events from up to 31 card slots into one interrupt. Each slot has a five-bit event latch. Hardware inputs set the latch bits, and software clears them by writing ones. Each slot also has a seven-bit mask byte. The block combines every slot with the command-completion flag into a 32-bit locator word. In that word, bit 0 means a controller command has finished and bit i+1 means slot i needs attention. From the locator and a global disable it forms one interrupt level.

When message signalling is off, the level drives a wired interrupt pin. When message signalling is on, the pin stays low and the block instead raises a one-cycle message pulse each time the level changes. The level is tracked on every cycle, so switching message mode on while the level is already high does not produce a pulse.

The register access decoder is not part of this block. Software writes arrive as direct strobes with a slot index. State is read back through a slot read select and the control outputs.

Top module: `slot_irq_agg`

## Requirements
- R1: After reset, every event latch and both detect flags are 0. Every slot mask reads 0x7F. The control bits read 0xF, where bit0 is interrupt disable, bit1 is error-report disable, bit2 is command-interrupt disable and bit3 is arbiter-error disable. The locator, `irq_level` and `msi_pulse` are all 0.
- R2: A 1 on `ev_set[s*5+b]` at a clock edge sets bit b of slot s's latch. The bit meanings are: 0x01 card presence, 0x02 isolated power fault, 0x04 attention button, 0x08 retention latch sensor, 0x10 connected power fault. The bit holds until software clears it.
- R3: A latch write with `lat_we` clears exactly those bits of slot `wr_slot` that are 1 in `lat_clr`. Writes to a slot index at or above NSLOT have no effect.
- R4: If a hardware set and a software clear hit the same latch bit or detect flag in the same cycle, the bit ends up set.
- R5: Locator bit s+1 is 1 exactly when slot s has a latched event whose matching mask bit (bits 4..0) is 0. Mask bits 6 and 5 are error-report disables and do not affect the locator. Locator bits above NSLOT are 0.
- R6: Locator bit 0 is 1 exactly when the command-detected flag (`flags_q[0]`, set by `cmd_done`) is 1 and control bit2 is 0. The arbiter-detected flag (`flags_q[1]`, set by `arb_err`) does not affect the locator.
- R7: The level is 1 when control bit0 is 0 and the locator is nonzero. `irq_level` equals this level while `msi_en` is 0, and is 0 while `msi_en` is 1.
- R8: The block keeps a copy of the last level, updated on every cycle. While `msi_en` is 1, `msi_pulse` is high for the one cycle in which the level differs from that copy.
- R9: `ctl_we` loads the four control bits from `ctl_data`. A 1 in `flag_clr` clears the matching detect flag, subject to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Message-signalled interrupt mode |
| ev_set | input | NSLOT*5 | Hardware event set pulses, 5 per slot |
| cmd_done | input | 1 | Sets the command-detected flag |
| arb_err | input | 1 | Sets the arbiter-detected flag |
| lat_we | input | 1 | Latch clear strobe |
| msk_we | input | 1 | Mask write strobe |
| wr_slot | input | SW | Slot targeted by latch or mask writes |
| lat_clr | input | 5 | Write-one-to-clear data for the latch |
| msk_data | input | 7 | New mask byte |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 4 | New control bits |
| flag_clr | input | 2 | Write-one-to-clear for the detect flags |
| rd_slot | input | SW | Slot shown on the read outputs |
| rd_latch | output | 5 | Latch of rd_slot |
| rd_mask | output | 7 | Mask of rd_slot |
| ctl_q | output | 4 | Control bits |
| flags_q | output | 2 | Arbiter-detected (bit1) and command-detected (bit0) flags |
| locator | output | 32 | Interrupt locator word |
| irq_level | output | 1 | Wired interrupt level |
| msi_pulse | output | 1 | One-cycle message request |

## Verification
Two actions can land on the same cycle: a hardware event setting a latch bit, and a software write-one-clear of that same bit. The bench drives both on one clock edge, first for a slot event bit and then for the command flag, and expects the bit to read back as set.

A second pair is a change of the interrupt level together with a change of mode. Message mode is enabled while the level is already high, and the bench expects no pulse and a silent pin. Single-cycle pulses are expected on each real rise and fall of the level.

// File: rtl/slot_irq_agg.sv
module slot_irq_agg #(
  parameter int NSLOT = 31,
  parameter int SW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msi_en,
  input  logic [NSLOT*5-1:0] ev_set,
  input  logic               cmd_done,
  input  logic               arb_err,
  input  logic               lat_we,
  input  logic               msk_we,
  input  logic [SW-1:0]      wr_slot,
  input  logic [4:0]         lat_clr,
  input  logic [6:0]         msk_data,
  input  logic               ctl_we,
  input  logic [3:0]         ctl_data,
  input  logic [1:0]         flag_clr,
  input  logic [SW-1:0]      rd_slot,
  output logic [4:0]         rd_latch,
  output logic [6:0]         rd_mask,
  output logic [3:0]         ctl_q,
  output logic [1:0]         flags_q,
  output logic [31:0]        locator,
  output logic               irq_level,
  output logic               msi_pulse
);
  localparam int EW = 5;
  localparam int MW = 7;

  logic [EW-1:0]      lat_q  [NSLOT];
  logic [MW-1:0]      mask_q [NSLOT];
  logic [NSLOT*EW-1:0] lat_flat;
  logic [NSLOT-1:0]   hit;
  logic               level, last_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire sel = (wr_slot == SW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_q[g]  <= '0;
        mask_q[g] <= '1;
      end else begin
        lat_q[g] <= (lat_q[g] & ~((lat_we && sel) ? lat_clr : '0)) | ev_set[g*EW +: EW];
        if (msk_we && sel) mask_q[g] <= msk_data;
      end
    end
    assign lat_flat[g*EW +: EW] = lat_q[g];
    assign hit[g] = |(lat_q[g] & ~mask_q[g][EW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= 4'hF;
      flags_q <= 2'b00;
      last_q  <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_data;
      flags_q <= (flags_q & ~flag_clr) | {arb_err, cmd_done};
      last_q  <= level;
    end
  end

  assign locator[0] = flags_q[0] & ~ctl_q[2];
  assign locator[NSLOT:1] = hit;
  if (NSLOT < 31) begin : g_pad
    assign locator[31:NSLOT+1] = '0;
  end

  assign level     = ~ctl_q[0] & (|locator);
  assign irq_level = level & ~msi_en;
  assign msi_pulse = msi_en & (level ^ last_q);

  assign rd_latch = (32'(rd_slot) < NSLOT) ? lat_q[rd_slot]  : '0;
  assign rd_mask  = (32'(rd_slot) < NSLOT) ? mask_q[rd_slot] : '0;
endmodule

module slot_irq_agg_chk #(
  parameter int NSLOT = 31
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msi_en,
  input logic [NSLOT*5-1:0] ev_set,
  input logic [NSLOT*5-1:0] lat_flat,
  input logic               cmd_done,
  input logic [1:0]         flags_q,
  input logic [3:0]         ctl_q,
  input logic [31:0]        locator,
  input logic               irq_level,
  input logic               msi_pulse
);
  // R4
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set != '0) |=> ((lat_flat & $past(ev_set)) == $past(ev_set)));
  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_flat & ~$past(lat_flat) & ~$past(ev_set)) == '0));
  // R4
  cmd_flag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> flags_q[0]);
  // R6
  cmd_bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locator[0] |-> (flags_q[0] && !ctl_q[2]));
  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> (!msi_en && !ctl_q[0] && locator != '0));
  // R8
  pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> msi_en);
endmodule

bind slot_irq_agg slot_irq_agg_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .ev_set(ev_set),
  .lat_flat(lat_flat), .cmd_done(cmd_done), .flags_q(flags_q),
  .ctl_q(ctl_q), .locator(locator), .irq_level(irq_level),
  .msi_pulse(msi_pulse)
);

// File: tb/tb_slot_irq_agg.sv
module tb_slot_irq_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 31;
  localparam int SW = 5;

  logic clk = 0, rst_n = 0, msi_en = 0;
  logic [NSLOT*5-1:0] ev_set = '0;
  logic cmd_done = 0, arb_err = 0, lat_we = 0, msk_we = 0, ctl_we = 0;
  logic [SW-1:0] wr_slot = '0, rd_slot = '0;
  logic [4:0] lat_clr = '0;
  logic [6:0] msk_data = '0;
  logic [3:0] ctl_data = '0;
  logic [1:0] flag_clr = '0;
  logic [4:0] rd_latch;
  logic [6:0] rd_mask;
  logic [3:0] ctl_q;
  logic [1:0] flags_q;
  logic [31:0] locator;
  logic irq_level, msi_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_irq_agg #(.NSLOT(NSLOT), .SW(SW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic pulse_ev(input int s, input logic [4:0] b);
    drive_edge(); ev_set[s*5 +: 5] = b;
    step(); ev_set = '0;
  endtask

  task automatic wr_mask(input int s, input logic [6:0] m);
    drive_edge(); msk_we = 1; wr_slot = SW'(s); msk_data = m;
    step(); msk_we = 0;
  endtask

  task automatic wr_clr(input int s, input logic [4:0] c);
    drive_edge(); lat_we = 1; wr_slot = SW'(s); lat_clr = c;
    step(); lat_we = 0;
  endtask

  task automatic wr_ctl(input logic [3:0] c);
    drive_edge(); ctl_we = 1; ctl_data = c;
    step(); ctl_we = 0;
  endtask

  task automatic t_reset();
    rd_slot = 0; #1;
    chk("R1 mask0", 32'(rd_mask), 32'h7F);
    chk("R1 latch0", 32'(rd_latch), 0);
    rd_slot = 30; #1;
    chk("R1 mask30", 32'(rd_mask), 32'h7F);
    chk("R1 ctl", 32'(ctl_q), 32'hF);
    chk("R1 flags", 32'(flags_q), 0);
    chk("R1 locator", locator, 0);
    chk("R1 irq", 32'(irq_level), 0);
    chk("R1 msi", 32'(msi_pulse), 0);
  endtask

  task automatic t_latch_mask();
    rd_slot = 3;
    pulse_ev(3, 5'h05);
    chk("R2 set", 32'(rd_latch), 32'h05);
    chk("R5 masked", locator, 0);
    step();
    chk("R2 hold", 32'(rd_latch), 32'h05);
    wr_mask(3, 7'h60);
    chk("R5 serr bits ignored", locator, 32'h10);
    wr_mask(3, 7'h05);
    chk("R5 all masked", locator, 0);
    wr_mask(3, 7'h7B);
    chk("R5 one unmasked", locator, 32'h10);
    wr_mask(3, 7'h60);
  endtask

  task automatic t_level();
    wr_ctl(4'h0);
    chk("R9 ctl", 32'(ctl_q), 0);
    chk("R7 irq", 32'(irq_level), 1);
    chk("R8 no pulse", 32'(msi_pulse), 0);
  endtask

  task automatic t_clear();
    rd_slot = 3;
    wr_clr(3, 5'h01);
    chk("R3 partial", 32'(rd_latch), 32'h04);
    chk("R3 still irq", 32'(irq_level), 1);
    wr_clr(31, 5'h1F);
    chk("R3 bad slot", 32'(rd_latch), 32'h04);
    wr_clr(3, 5'h04);
    chk("R3 full", 32'(rd_latch), 0);
    chk("R3 locator", locator, 0);
    chk("R7 low", 32'(irq_level), 0);
  endtask

  task automatic t_race();
    rd_slot = 3;
    drive_edge(); ev_set[3*5 +: 5] = 5'h08; lat_we = 1; wr_slot = 3; lat_clr = 5'h08;
    step(); ev_set = '0; lat_we = 0;
    chk("R4 set wins", 32'(rd_latch), 32'h08);
    wr_clr(3, 5'h08);
    chk("R4 cleared later", 32'(rd_latch), 0);
  endtask

  task automatic t_msi();
    wr_mask(5, 7'h00);
    drive_edge(); msi_en = 1;
    step();
    chk("R8 quiet", 32'(msi_pulse), 0);
    pulse_ev(5, 5'h10);
    chk("R8 rise pulse", 32'(msi_pulse), 1);
    chk("R7 pin quiet", 32'(irq_level), 0);
    step();
    chk("R8 single", 32'(msi_pulse), 0);
    wr_clr(5, 5'h10);
    chk("R8 fall pulse", 32'(msi_pulse), 1);
    step();
    chk("R8 fall single", 32'(msi_pulse), 0);
    drive_edge(); msi_en = 0;
    pulse_ev(5, 5'h02);
    chk("R7 pin high", 32'(irq_level), 1);
    step();
    drive_edge(); msi_en = 1; #1;
    chk("R8 enable no pulse", 32'(msi_pulse), 0);
    chk("R7 pin off in msi", 32'(irq_level), 0);
    step();
    chk("R8 still none", 32'(msi_pulse), 0);
    drive_edge(); msi_en = 0;
    wr_clr(5, 5'h02);
    chk("R7 cleared", 32'(irq_level), 0);
  endtask

  task automatic t_top_slot();
    wr_mask(30, 7'h00);
    pulse_ev(30, 5'h01);
    chk("R5 top bit", locator, 32'h8000_0000);
    wr_clr(30, 5'h01);
    chk("R5 top clear", locator, 0);
  endtask

  task automatic t_cmd();
    drive_edge(); cmd_done = 1;
    step(); cmd_done = 0;
    chk("R6 flag", 32'(flags_q), 1);
    chk("R6 loc0", locator, 1);
    chk("R7 cmd irq", 32'(irq_level), 1);
    wr_ctl(4'h4);
    chk("R6 cmd dis", locator, 0);
    chk("R7 none", 32'(irq_level), 0);
    wr_ctl(4'h1);
    chk("R6 back", locator, 1);
    chk("R7 global dis", 32'(irq_level), 0);
    drive_edge(); arb_err = 1;
    step(); arb_err = 0;
    chk("R6 arb flag", 32'(flags_q), 3);
    chk("R6 arb no loc", locator, 1);
    drive_edge(); cmd_done = 1; flag_clr = 2'b01;
    step(); cmd_done = 0; flag_clr = 0;
    chk("R4 flag wins", 32'(flags_q), 3);
    drive_edge(); flag_clr = 2'b11;
    step(); flag_clr = 0;
    chk("R9 flags clr", 32'(flags_q), 0);
    chk("R9 loc clr", locator, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    drive_edge(); rst_n = 1;
    step();
    t_reset();
    t_latch_mask();
    t_level();
    t_clear();
    t_race();
    t_msi();
    t_top_slot();
    t_cmd();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule